// File: doc/BRIEF.md
# Monitor Channel Message Receiver

This block sits on the receive side of a frame-based serial control channel. Once per 8 kHz frame it takes one data byte together with a sender flag that is active low. From these it rebuilds a multi-byte message one byte at a time. A byte is accepted only when the same value arrives in two frames in a row while the local consumer reports that it is ready. The block answers the sender through an active-low acknowledge flag, which it drives at frame rate.

The first byte of a message is acknowledged by a level change: the flag goes low and stays low. Each later byte is announced by the sender flag going high for one frame. Each later byte is acknowledged by one frame with the flag high, followed by a return to low. If no byte is accepted for a set number of comparison frames (8 by default), the receiver requests an abort and raises a status output. The acknowledge pattern for an abort on the first byte differs from the pattern for an abort on a later byte. If the sender flag stays high for two frames in a row, the message ends.

Every accepted byte is presented for one clock cycle on a strobe with its data. The end of a message gives its own one-cycle strobe. Storing the message and decoding its contents are left to the consumer.

Top module: `mon_msg_rx`

## Requirements
- R1: After reset, and in idle, ack_flag_n is 1, rx_strobe and eom_strobe are 0 and abort_req is 0. In idle, frames with msg_flag_n = 1 change none of these.
- R2: In idle, a frame with msg_flag_n = 0 starts a message and takes its byte as the first copy. ack_flag_n stays 1.
- R3: A byte is accepted only when the frame carries the same byte as the previous frame and rdy = 1. One cycle after that frame strobe, rx_strobe is 1 for exactly one cycle and rx_data holds the byte. With rdy = 0 the byte is not accepted.
- R4: When the first byte is accepted, ack_flag_n goes to 0 and stays 0 until the next byte is accepted or the message ends.
- R5: A frame with msg_flag_n = 1 after an accepted byte supplies the first copy of the next byte. When that byte is accepted, ack_flag_n is 1 for the following frame and 0 from the frame after it.
- R6: A comparison frame that does not accept its byte (differing byte, or rdy = 0) counts one failure, and its byte becomes the copy for the next comparison. The failure count restarts at every new byte.
- R7: On the 8th failure for the first byte, abort_req goes to 1 and ack_flag_n is 0 for one frame, then 1.
- R8: On the 8th failure for a later byte, abort_req goes to 1 and ack_flag_n goes to 1 and stays at 1.
- R9: While a later byte is awaited, a second consecutive frame with msg_flag_n = 1 ends the message. eom_strobe is 1 for one cycle, ack_flag_n returns to 1 and the block goes back to idle.
- R10: abort_req stays 1 until the block sees msg_flag_n = 1 in two consecutive frames. It then clears and the block goes back to idle, with no eom_strobe.
- R11: ack_flag_n, rx_strobe, eom_strobe and abort_req change only on the cycle that follows a frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_tick | input | 1 | One-cycle strobe; samples this frame's byte, flag and ready |
| mon_byte | input | DW | Byte carried by the current frame |
| msg_flag_n | input | 1 | Sender flag, active low |
| rdy | input | 1 | Consumer can take a byte |
| ack_flag_n | output | 1 | Acknowledge flag returned to the sender, active low |
| rx_strobe | output | 1 | One-cycle pulse for an accepted byte |
| rx_data | output | DW | Last accepted byte |
| eom_strobe | output | 1 | One-cycle pulse at end of message |
| abort_req | output | 1 | Abort request status |

## Verification
The bench builds the block with its default parameters: 8-bit bytes and a limit of 8 failures. With these values it can sweep every failure count from zero up to the abort point, for both the first byte and a later byte. It also sweeps message lengths of one to four bytes, once with the next byte sent straight after the pre-acknowledge and once with it sent a frame later. Further cases hold the consumer not ready while identical copies arrive, and check that the abort state is left only after two consecutive inactive flag frames.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,  // no message in progress
    ST_FIRST    = 3'd1,  // comparing copies of the first byte
    ST_WAIT     = 3'd2,  // byte acknowledged, awaiting the next one
    ST_PREACK   = 3'd3,  // pre-acknowledge frame of a later byte
    ST_NEXT     = 3'd4,  // comparing copies of a later byte
    ST_AB_FIRST = 3'd5,  // single low frame of a first-byte abort
    ST_AB_HOLD  = 3'd6   // abort requested, awaiting two idle frames
  } rx_state_t;

  // A byte is accepted when this frame repeats the previous one and the
  // consumer is ready.
  function automatic logic copy_accepted(input logic [63:0] cur,
                                         input logic [63:0] prev,
                                         input logic        ready);
    return ready && (cur == prev);
  endfunction

  // True when one more failure reaches the limit.
  function automatic logic tries_spent(input int unsigned cnt,
                                       input int unsigned limit);
    return (cnt + 1) >= limit;
  endfunction

endpackage

// File: rtl/mrx_copy_store.sv
module mrx_copy_store #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] held
);

  // Keeps the byte of the most recent frame, so that each frame can be
  // compared with the one before it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      held <= '0;
    else if (load)
      held <= din;
  end

endmodule

// File: rtl/mrx_try_counter.sv
module mrx_try_counter #(
  parameter int TRY_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic at_edge
);
  import mrx_pkg::*;

  localparam int CW = $clog2(TRY_LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (bump)
      cnt <= cnt + CW'(1);
  end

  // The next failure would be the last one allowed.
  assign at_edge = tries_spent(int'(unsigned'(cnt)), TRY_LIMIT);

endmodule

// File: rtl/mrx_seq.sv
module mrx_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic msg_flag_n,
  input  logic accepted,
  input  logic at_edge,
  output logic ack_flag_n,
  output logic abort_req,
  output logic cap_ev,
  output logic miss_ev,
  output logic validate_ev,
  output logic abort_ev,
  output logic eom_ev,
  output logic quit_ev
);
  import mrx_pkg::*;

  rx_state_t state, state_nxt;
  logic      ack_nxt;
  logic      flag_prev_hi;

  always_comb begin
    state_nxt   = state;
    ack_nxt     = ack_flag_n;
    cap_ev      = 1'b0;
    miss_ev     = 1'b0;
    validate_ev = 1'b0;
    abort_ev    = 1'b0;
    eom_ev      = 1'b0;
    quit_ev     = 1'b0;
    if (frame_tick) begin
      unique case (state)
        ST_IDLE: begin
          if (!msg_flag_n) begin
            cap_ev    = 1'b1;
            state_nxt = ST_FIRST;
          end
        end
        ST_FIRST: begin
          if (accepted) begin
            validate_ev = 1'b1;
            ack_nxt     = 1'b0;
            state_nxt   = ST_WAIT;
          end else begin
            miss_ev = 1'b1;
            if (at_edge) begin
              abort_ev  = 1'b1;
              ack_nxt   = 1'b0;
              state_nxt = ST_AB_FIRST;
            end
          end
        end
        ST_WAIT, ST_PREACK: begin
          ack_nxt = 1'b0;
          if (msg_flag_n) begin
            cap_ev    = 1'b1;
            state_nxt = ST_NEXT;
          end else begin
            state_nxt = ST_WAIT;
          end
        end
        ST_NEXT: begin
          if (msg_flag_n) begin
            eom_ev    = 1'b1;
            ack_nxt   = 1'b1;
            state_nxt = ST_IDLE;
          end else if (accepted) begin
            validate_ev = 1'b1;
            ack_nxt     = 1'b1;
            state_nxt   = ST_PREACK;
          end else begin
            miss_ev = 1'b1;
            if (at_edge) begin
              abort_ev  = 1'b1;
              ack_nxt   = 1'b1;
              state_nxt = ST_AB_HOLD;
            end
          end
        end
        ST_AB_FIRST: begin
          ack_nxt   = 1'b1;
          state_nxt = ST_AB_HOLD;
        end
        ST_AB_HOLD: begin
          ack_nxt = 1'b1;
          if (msg_flag_n && flag_prev_hi) begin
            quit_ev   = 1'b1;
            state_nxt = ST_IDLE;
          end
        end
        default: begin
          ack_nxt   = 1'b1;
          state_nxt = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      ack_flag_n   <= 1'b1;
      abort_req    <= 1'b0;
      flag_prev_hi <= 1'b0;
    end else begin
      state      <= state_nxt;
      ack_flag_n <= ack_nxt;
      if (frame_tick)
        flag_prev_hi <= msg_flag_n;
      if (abort_ev)
        abort_req <= 1'b1;
      else if (quit_ev)
        abort_req <= 1'b0;
    end
  end

endmodule

// File: rtl/mon_msg_rx.sv
module mon_msg_rx #(
  parameter int DW        = 8,
  parameter int TRY_LIMIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_tick,
  input  logic [DW-1:0] mon_byte,
  input  logic          msg_flag_n,
  input  logic          rdy,
  output logic          ack_flag_n,
  output logic          rx_strobe,
  output logic [DW-1:0] rx_data,
  output logic          eom_strobe,
  output logic          abort_req
);
  import mrx_pkg::*;

  // Named internal events, also visible to the bound checker.
  logic [DW-1:0] prev_byte;
  logic          accepted;
  logic          at_edge;
  logic          cap_ev;
  logic          miss_ev;
  logic          validate_ev;
  logic          abort_ev;
  logic          eom_ev;
  logic          quit_ev;

  mrx_copy_store #(.DW(DW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (frame_tick),
    .din   (mon_byte),
    .held  (prev_byte)
  );

  assign accepted = copy_accepted(64'(mon_byte), 64'(prev_byte), rdy);

  mrx_try_counter #(.TRY_LIMIT(TRY_LIMIT)) u_tries (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cap_ev),
    .bump    (miss_ev),
    .at_edge (at_edge)
  );

  mrx_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_tick  (frame_tick),
    .msg_flag_n  (msg_flag_n),
    .accepted    (accepted),
    .at_edge     (at_edge),
    .ack_flag_n  (ack_flag_n),
    .abort_req   (abort_req),
    .cap_ev      (cap_ev),
    .miss_ev     (miss_ev),
    .validate_ev (validate_ev),
    .abort_ev    (abort_ev),
    .eom_ev      (eom_ev),
    .quit_ev     (quit_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_strobe  <= 1'b0;
      eom_strobe <= 1'b0;
      rx_data    <= '0;
    end else begin
      rx_strobe  <= validate_ev;
      eom_strobe <= eom_ev;
      if (validate_ev)
        rx_data <= mon_byte;
    end
  end

endmodule

// File: rtl/mrx_checker.sv
module mrx_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_tick,
  input logic [DW-1:0] mon_byte,
  input logic          msg_flag_n,
  input logic          rdy,
  input logic          ack_flag_n,
  input logic          rx_strobe,
  input logic [DW-1:0] rx_data,
  input logic          eom_strobe,
  input logic          abort_req,
  input logic          validate_ev,
  input logic          abort_ev,
  input logic          eom_ev,
  input logic          quit_ev
);

  // R11
  ack_frame_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(ack_flag_n));

  // R11
  abort_frame_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(abort_req));

  // R3
  rx_data_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> (rx_data == $past(mon_byte)) && $past(rdy) && $past(frame_tick));

  // R3
  rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> !rx_strobe);

  // R3
  validate_to_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    validate_ev |=> rx_strobe);

  // R9
  eom_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eom_strobe |-> ack_flag_n && !rx_strobe && !abort_req);

  // R9
  eom_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eom_ev |-> msg_flag_n);

  // R10
  abort_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> abort_req);

  // R10
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(abort_req) |-> $past(msg_flag_n) && $past(frame_tick) && $past(quit_ev));

  // R6
  single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({validate_ev, abort_ev, eom_ev, quit_ev}));

endmodule

bind mon_msg_rx mrx_checker #(.DW(DW)) u_chk (.*);

// File: tb/sim_mon_msg_rx.sv
`timescale 1ns/1ps
module sim_mon_msg_rx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0;
  logic [7:0] mon_byte = '0;
  logic       msg_flag_n = 1'b1;
  logic       rdy = 1'b1;
  logic       ack_flag_n;
  logic       rx_strobe;
  logic [7:0] rx_data;
  logic       eom_strobe;
  logic       abort_req;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mon_msg_rx u0 (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .mon_byte(mon_byte),
    .msg_flag_n(msg_flag_n), .rdy(rdy), .ack_flag_n(ack_flag_n),
    .rx_strobe(rx_strobe), .rx_data(rx_data), .eom_strobe(eom_strobe),
    .abort_req(abort_req)
  );

  // Byte j of a failing run: consecutive values always differ.
  function automatic logic [7:0] fb(input logic [7:0] base, input int j);
    return base ^ (8'(j) * 8'h11);
  endfunction

  task automatic frame(input logic [7:0] b, input logic fl, input logic r,
                       input logic xa, input logic xrx, input logic [7:0] xd,
                       input logic xeom, input logic xab, input string req);
    @(negedge clk);
    mon_byte = b; msg_flag_n = fl; rdy = r; frame_tick = 1'b1;
    @(posedge clk); #1;
    checks++;
    if (ack_flag_n !== xa || rx_strobe !== xrx || (xrx && rx_data !== xd) ||
        eom_strobe !== xeom || abort_req !== xab) begin
      errors++;
      $display("FAIL %s: ack=%b rx=%b data=%h eom=%b abort=%b, expected ack=%b rx=%b data=%h eom=%b abort=%b",
               req, ack_flag_n, rx_strobe, rx_data, eom_strobe, abort_req,
               xa, xrx, xd, xeom, xab);
    end
    @(negedge clk); frame_tick = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (ack_flag_n !== xa || rx_strobe !== 1'b0 || eom_strobe !== 1'b0 || abort_req !== xab) begin
      errors++;
      $display("FAIL R11 between frames: ack=%b rx=%b eom=%b abort=%b, expected ack=%b rx=0 eom=0 abort=%b",
               ack_flag_n, rx_strobe, eom_strobe, abort_req, xa, xab);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (ack_flag_n !== 1'b1 || rx_strobe !== 1'b0 || eom_strobe !== 1'b0 || abort_req !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: ack=%b rx=%b eom=%b abort=%b, expected 1 0 0 0",
               ack_flag_n, rx_strobe, eom_strobe, abort_req);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: an inactive flag in idle leaves everything at rest
    frame(8'h12, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R1 idle");
    frame(8'h12, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R1 idle");

    // Message lengths 1..4, next byte sent at once or one frame late
    for (int len = 1; len <= 4; len++) begin
      for (int late = 0; late <= 1; late++) begin
        logic [7:0] b0;
        b0 = 8'(8'h10 * len + 8'h03 + late);
        frame(b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R2 start");
        frame(b0, 1'b0, 1'b1, 1'b0, 1'b1, b0, 1'b0, 1'b0, "R3 R4 first accept");
        for (int i = 1; i < len; i++) begin
          logic [7:0] bi;
          bi = 8'(b0 + 8'h25 * i);
          frame(bi, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R5 announce");
          frame(bi, 1'b0, 1'b1, 1'b1, 1'b1, bi, 1'b0, 1'b0, "R5 pre-ack");
          if (late != 0)
            frame(bi, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R5 ack");
        end
        frame(8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R9 first idle frame");
        frame(8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R9 end of message");
      end
    end

    // First byte: k failures (0..8) before acceptance or abort
    for (int k = 0; k <= 8; k++) begin
      logic [7:0] base;
      base = 8'(8'h40 + 3 * k);
      frame(base, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R2 start");
      for (int j = 1; j <= k; j++)
        frame(fb(base, j), 1'b0, 1'b1, (j == 8) ? 1'b0 : 1'b1, 1'b0, 8'h00, 1'b0,
              (j == 8), (j == 8) ? "R7 abort first" : "R6 first miss");
      if (k < 8) begin
        frame(fb(base, k), 1'b0, 1'b1, 1'b0, 1'b1, fb(base, k), 1'b0, 1'b0, "R6 accept after misses");
        frame(8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R9 first idle frame");
        frame(8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R9 end of message");
      end else begin
        frame(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R7 single low frame");
        frame(8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R10 held after one idle frame");
        frame(8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R10 cleared");
      end
    end

    // Later byte: k failures (0..8) before acceptance or abort
    for (int k = 0; k <= 8; k++) begin
      logic [7:0] c;
      c = 8'(8'hC0 + k);
      frame(8'h5A, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R2 start");
      frame(8'h5A, 1'b0, 1'b1, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, "R4 first accept");
      frame(fb(c, 0), 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R5 announce");
      for (int j = 1; j <= k; j++)
        frame(fb(c, j), 1'b0, 1'b1, (j == 8), 1'b0, 8'h00, 1'b0,
              (j == 8), (j == 8) ? "R8 abort later" : "R6 later miss");
      if (k < 8) begin
        frame(fb(c, k), 1'b0, 1'b1, 1'b1, 1'b1, fb(c, k), 1'b0, 1'b0, "R6 accept after misses");
        frame(fb(c, k), 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R5 ack");
        frame(8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R9 first idle frame");
        frame(8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R9 end of message");
      end else begin
        frame(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R8 stays inactive");
        frame(8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R10 held after one idle frame");
        frame(8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R10 cleared");
      end
    end

    // R3: identical copies are not accepted while the consumer is not ready
    frame(8'h77, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R2 start");
    frame(8'h77, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R3 not ready first");
    frame(8'h77, 1'b0, 1'b1, 1'b0, 1'b1, 8'h77, 1'b0, 1'b0, "R3 ready first");
    frame(8'h88, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R5 announce");
    frame(8'h88, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R3 not ready later");
    frame(8'h88, 1'b0, 1'b1, 1'b1, 1'b1, 8'h88, 1'b0, 1'b0, "R3 ready later");
    frame(8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R9 first idle frame");
    frame(8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R9 end of message");
    frame(8'h33, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R1 idle after end");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule